// File: doc/BRIEF.md
# Shared-Datapath I/Q Interpolate-by-Two FIR

This block doubles the sample rate of one complex baseband stream. In-phase and quadrature samples arrive interleaved on one input bus. Each sample carries a valid flag and a tag that says which component it belongs to. Each component keeps its own history of input samples. One bank of slot multipliers and one adder tree serve both components and both output phases, one after the other in time.

Upsampling inserts a zero between consecutive samples of a component. The block uses a polyphase split so that it never multiplies those zeros. For every accepted sample it computes two outputs. The first uses the even-indexed taps of the 79-tap prototype. The second uses the odd-indexed taps, and its missing last tap is treated as a zero. The sum is kept at full width, and each output carries the tag of the component it came from.

In normal use the samples of a stream come every second clock, for example I, gap, Q, gap. This gives exactly one output on every clock.

Top module: `iq_interp2_fir`

## Requirements
- R1: While rst_n is low, out_valid and out_data are 0. Reset also clears both sample histories, so the outputs after reset behave as if every earlier sample had been zero.
- R2: Tap j (0..78) holds the value h[j] = s * 80 * (1600 - d*d), where d = |j - 39|. The sign s is -1 when d mod 5 equals 2, and +1 otherwise. Feeding a single 1 followed by zeros into one component therefore returns h[0], h[1], h[2], ... in that order.
- R3: A sample accepted at clock edge k gives a phase-0 output that is visible after edge k+1. That output equals the sum over m of h[2m] times the m-th newest sample of the same component (m = 0..39, where m = 0 is the sample just accepted). out_phase is 0 for this output.
- R4: Unless a new sample is accepted at edge k+1, a phase-1 output follows after edge k+2. It equals the sum over m of h[2m+1] times the m-th newest sample of the same component (m = 0..38). out_phase is 1 for this output.
- R5: in_q = 0 selects the I history and in_q = 1 selects the Q history. A sample never enters the other history. out_q repeats the tag of the sample that produced the output.
- R6: out_data is the exact two's-complement sum, 41 bits wide. It does not wrap or truncate, even with full-scale inputs.
- R7: If a sample is accepted at edge k+1, right after one accepted at edge k, the earlier sample's phase-1 output is dropped. The new sample's phase-0 output follows after edge k+2.
- R8: A sample accepted on the same edge that emits the previous sample's phase-1 output does not change that phase-1 value.
- R9: out_valid is 1 only for the outputs described in R3 and R4, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_q | input | 1 | Input tag: 0 = I, 1 = Q |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_q | output | 1 | Output tag: 0 = I, 1 = Q |
| out_phase | output | 1 | Output polyphase branch: 0 first, 1 second |
| out_data | output | 41 | Signed full-precision output sample |

## Verification
Two events overlap when samples arrive every second clock. The previous sample's phase-1 output leaves the register on the same edge that the next sample shifts into a history. The shared adder tree and the output register must keep those two apart. Long interleaved runs at this spacing provoke the overlap; random spacings and full-scale values are mixed in, and so are pairs of back-to-back samples that must drop a phase-1 output. The bench judges every cycle against a direct-form model that inserts the zeros explicitly and keeps a separate history per component.

// File: rtl/iq_interp2_fir.sv
module iq_interp2_fir #(
  parameter int DW = 16,
  parameter int CW = 18,
  parameter int TAPS = 79,
  parameter int CSCALE = 80,
  localparam int SLOTS = (TAPS + 1) / 2,
  localparam int OW = DW + CW + $clog2(SLOTS) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_q,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic                 out_q,
  output logic                 out_phase,
  output logic signed [OW-1:0] out_data
);

  localparam int PW = DW + CW;
  localparam int MID = (TAPS - 1) / 2;

  function automatic int coef(input int j);
    int d, m;
    d = (j > MID) ? j - MID : MID - j;
    m = CSCALE * ((MID + 1) * (MID + 1) - d * d);
    if (d % 5 == 2) m = -m;
    return m;
  endfunction

  logic signed [DW-1:0] line_i [SLOTS];
  logic signed [DW-1:0] line_q [SLOTS];
  logic                 calc_v, calc_ph, calc_q;
  logic signed [DW-1:0] tapv [SLOTS];
  logic signed [CW-1:0] cf   [SLOTS];
  logic signed [PW-1:0] prod [SLOTS];
  logic signed [OW-1:0] acc;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    localparam logic signed [CW-1:0] CEVEN = CW'(coef(2 * k));
    localparam logic signed [CW-1:0] CODD  = (2 * k + 1 < TAPS) ? CW'(coef(2 * k + 1)) : CW'(0);
    assign tapv[k] = calc_q ? line_q[k] : line_i[k];
    assign cf[k]   = calc_ph ? CODD : CEVEN;
    assign prod[k] = PW'(tapv[k]) * PW'(cf[k]);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < SLOTS; k++) acc = acc + OW'(prod[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < SLOTS; k++) begin
        line_i[k] <= '0;
        line_q[k] <= '0;
      end
      calc_v    <= 1'b0;
      calc_ph   <= 1'b0;
      calc_q    <= 1'b0;
      out_valid <= 1'b0;
      out_q     <= 1'b0;
      out_phase <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_valid) begin
        if (in_q) begin
          line_q[0] <= in_data;
          for (int k = 1; k < SLOTS; k++) line_q[k] <= line_q[k-1];
        end else begin
          line_i[0] <= in_data;
          for (int k = 1; k < SLOTS; k++) line_i[k] <= line_i[k-1];
        end
        calc_v  <= 1'b1;
        calc_ph <= 1'b0;
        calc_q  <= in_q;
      end else if (calc_v && !calc_ph) begin
        calc_ph <= 1'b1;
      end else begin
        calc_v <= 1'b0;
      end
      out_valid <= calc_v;
      if (calc_v) begin
        out_data  <= acc;
        out_q     <= calc_q;
        out_phase <= calc_ph;
      end
    end
  end

  assert_phase0_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 (out_valid && !out_phase && out_q == $past(in_q, 2)));

  assert_phase1_pairing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_phase) |-> ($past(out_valid) && !$past(out_phase) && $past(out_q) == out_q));

  assert_phase1_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_phase && !$past(in_valid)) |=> (out_valid && out_phase && out_q == $past(out_q)));

  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_phase) |-> $past(in_valid, 2));

endmodule

// File: tb/sim_iq_interp2_fir.sv
`timescale 1ns/1ps
module sim_iq_interp2_fir;
  localparam int DW = 16, CW = 18, TAPS = 79, OW = 41;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, in_q, out_valid, out_q, out_phase;
  logic signed [DW-1:0] in_data;
  logic signed [OW-1:0] out_data;

  iq_interp2_fir u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_q(in_q),
    .in_data(in_data), .out_valid(out_valid), .out_q(out_q), .out_phase(out_phase),
    .out_data(out_data));

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  longint hist [2][TAPS];
  bit sv [4]; bit sq [4]; bit sp [4]; longint sd [4]; string sr [4];

  function automatic longint hcoef(input int j);
    int c, d;
    longint m;
    c = (TAPS - 1) / 2;
    d = (j > c) ? j - c : c - j;
    m = 80 * ((c + 1) * (c + 1) - d * d);
    if (d % 5 == 2) m = -m;
    return m;
  endfunction

  function automatic longint dot(input int q);
    longint s = 0;
    for (int j = 0; j < TAPS; j++) s += hcoef(j) * hist[q][j];
    return s;
  endfunction

  task automatic push(input int q, input longint x);
    for (int j = TAPS - 1; j > 0; j--) hist[q][j] = hist[q][j-1];
    hist[q][0] = x;
  endtask

  task automatic chk(input string r, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int q = 0; q < 2; q++) for (int j = 0; j < TAPS; j++) hist[q][j] = 0;
    for (int s = 0; s < 4; s++) sv[s] = 0;
  endtask

  task automatic step(input bit v, input bit q, input logic signed [DW-1:0] d, input string tag);
    int s, s1, s2, s3;
    bit ab;
    longint e0, e1;
    @(negedge clk);
    s = cyc % 4;
    if (sv[s]) begin
      chk(sr[s], out_valid == 1'b1, out_valid, 1);
      if (out_valid) begin
        chk(sr[s], longint'(out_data) == sd[s], longint'(out_data), sd[s]);
        chk("R5", out_q == sq[s], out_q, sq[s]);
        chk(sr[s], out_phase == sp[s], out_phase, sp[s]);
      end
    end else begin
      chk("R9", out_valid == 1'b0, out_valid, 0);
    end
    sv[s] = 0;
    in_valid = v; in_q = q; in_data = d;
    if (v) begin
      s1 = (cyc + 1) % 4; s2 = (cyc + 2) % 4; s3 = (cyc + 3) % 4;
      if (sv[s1] && sp[s1]) sr[s1] = "R8";
      ab = sv[s2] && sp[s2];
      push(q, longint'(d)); e0 = dot(q);
      push(q, 0);           e1 = dot(q);
      sv[s2] = 1; sd[s2] = e0; sq[s2] = q; sp[s2] = 0;
      sr[s2] = (tag != "") ? tag : (ab ? "R7" : "R3");
      sv[s3] = 1; sd[s3] = e1; sq[s3] = q; sp[s3] = 1;
      sr[s3] = (tag != "") ? tag : "R4";
    end
    cyc++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0;
    repeat (3) @(negedge clk);
    chk("R1", out_valid == 1'b0, out_valid, 0);
    chk("R1", out_data == '0, longint'(out_data), 0);
    rst_n = 1;
    clear_model();
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    rst_n = 0; in_valid = 0; in_q = 0; in_data = '0;
    clear_model();
    do_reset();

    // R2 impulse on I, zeros interleaved on Q (R5 separation)
    step(1, 0, 16'sd1, "R2");
    step(0, 0, '0, "");
    for (int n = 0; n < 42; n++) begin
      step(1, 1, '0, "R5");
      step(0, 0, '0, "");
      step(1, 0, '0, "R2");
      step(0, 0, '0, "");
    end
    repeat (4) step(0, 0, '0, "");

    // random interleaved stream at two-cycle spacing (R3, R4, R8)
    for (int n = 0; n < 300; n++) begin
      step(1, n[0], DW'($urandom), "");
      step(0, 0, '0, "");
    end
    repeat (4) step(0, 0, '0, "");

    // R6 full-scale
    for (int n = 0; n < 45; n++) begin
      step(1, 0, -16'sd32768, "R6");
      step(0, 0, '0, "");
      step(1, 1, 16'sd32767, "R6");
      step(0, 0, '0, "");
    end
    repeat (4) step(0, 0, '0, "");

    // random spacing, random tags, including back-to-back pairs (R7)
    for (int n = 0; n < 600; n++) begin
      int gap;
      gap = int'($urandom % 4);
      step(1, 1'($urandom), DW'($urandom), "");
      for (int g = 0; g < gap; g++) step(0, 0, '0, "");
    end
    repeat (4) step(0, 0, '0, "");

    // R1: history cleared by a reset in mid-run
    do_reset();
    step(1, 1, 16'sd1234, "R1");
    step(0, 0, '0, "");
    step(1, 1, -16'sd77, "R1");
    repeat (6) step(0, 0, '0, "");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule